// File: doc/BRIEF.md
# Master clock ratio detector

This block works out, with no configuration input, how fast the master clock runs relative to the audio frame clock. It counts master-clock rising edges from one frame-clock rising edge to the next. It then sorts that count into one of four multiples of the sample rate: 128, 256, 512 or 768. A classification must repeat on two frames in a row before it is published as a ratio code and a locked flag. Interpolation and modulator timing further down the chip use these two outputs. When the master clock runs at 128 times the sample rate, a separate flag tells the modulator to oversample by 64 instead of 128.

A second counter runs on an always-on reference clock. It watches for master-clock activity and requests power-down once the master clock has been silent for a set number of reference cycles. The request drops as soon as activity returns. The ratio and lock state are held while the master clock is stopped.

The frame clock is brought into the master-clock domain through a two-flop synchroniser. Activity of the master clock reaches the reference domain as a toggle, passed through a second synchroniser. The single reset is active high and sampled synchronously in both domains, so it must be held while both clocks run.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is applied, and immediately after it is released, ratio_code is 2'b01, locked is 0, osr_half is 0 and pwrdn_req is 0.
- R2: A frame period of P master-clock cycles is classified as ratio 2'b00, 2'b01, 2'b10 or 2'b11 when P lies within RATIO_TOL (default 2) of 128, 256, 512 or 768 respectively.
- R3: The first frame-clock rising edge after reset starts a measurement and produces no classification. ratio_code changes, and locked rises, only on the second of two consecutive frames with the same classification.
- R4: A frame whose period is outside every window clears locked and the pending candidate, and ratio_code keeps its previous value.
- R5: osr_half is 1 exactly when ratio_code is 2'b00, and 0 for every other code.
- R6: A frame period of 2047 master-clock cycles or more counts as out of every window. When the frame clock has no rising edge for 2047 master-clock cycles, locked falls without waiting for the next edge, and ratio_code is kept.
- R7: When no master-clock edge is seen for STOP_TIMEOUT reference-clock cycles, pwrdn_req rises. It stays low before that interval has elapsed.
- R8: pwrdn_req falls within a few reference cycles of the first master-clock edge after a stop. ratio_code and locked are unchanged across the stop.
- R9: While locked, a single in-window frame that classifies differently from the current ratio clears locked and leaves ratio_code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock being measured |
| ref_clk | input | 1 | Always-on reference clock for stop detection |
| rst | input | 1 | Synchronous active-high reset for both domains |
| lrclk | input | 1 | Frame clock, one rising edge per sample frame |
| ratio_code | output | 2 | 00=128fs, 01=256fs, 10=512fs, 11=768fs |
| locked | output | 1 | Ratio confirmed on two consecutive frames |
| osr_half | output | 1 | Selects 64x oversampling (128fs case) |
| pwrdn_req | output | 1 | Master clock stopped, power-down requested |

## Verification
The most delicate coincidence is a frame-clock rising edge that arrives on the very cycle the missing-edge counter would saturate. In that cycle the frame measurement and the overrun event compete. The bench provokes this with a frame of exactly 2047 cycles. The design must take the edge, record a saturated out-of-window count and emit no separate overrun. This is judged by locked falling, ratio_code holding, and relock following after exactly two good frames. A second overlap is a master-clock stop while a lock is held. Here the reference-domain request must rise with the lock and ratio frozen, then clear on resumption before any new frame is judged.

// File: rtl/mcrd_pkg.sv
package mcrd_pkg;

    typedef enum logic [1:0] {
        RATIO_128 = 2'b00,
        RATIO_256 = 2'b01,
        RATIO_512 = 2'b10,
        RATIO_768 = 2'b11
    } ratio_e;

    localparam int NUM_RATIOS      = 4;
    localparam int BASE_FS_MULT    = 128;
    localparam int LARGEST_NOMINAL = BASE_FS_MULT * 6;

    // Outcome of judging one measured frame period
    typedef struct packed {
        logic   hit;
        ratio_e cls;
    } verdict_t;

    // Nominal master-clock cycles per frame for ratio index idx
    function automatic int nominal_of(input int idx);
        return (idx < 3) ? (BASE_FS_MULT << idx) : LARGEST_NOMINAL;
    endfunction

endpackage

// File: rtl/mcrd_sync.sv
module mcrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mcrd_frame_meter.sv
module mcrd_frame_meter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lr_sync,
    output logic             frame_vld,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             lr_prev;
    logic             armed;
    logic [CNT_W-1:0] run_cnt;
    logic             rise;

    assign rise = lr_sync & ~lr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_prev   <= 1'b0;
            armed     <= 1'b0;
            run_cnt   <= '0;
            frame_vld <= 1'b0;
            frame_cnt <= '0;
            overrun   <= 1'b0;
        end else begin
            lr_prev   <= lr_sync;
            frame_vld <= 1'b0;
            overrun   <= 1'b0;
            if (rise) begin
                run_cnt <= '0;
                armed   <= 1'b1;
                if (armed) begin
                    frame_vld <= 1'b1;
                    frame_cnt <= (run_cnt == CNT_MAX) ? CNT_MAX : run_cnt + 1'b1;
                end
            end else if (run_cnt != CNT_MAX) begin
                run_cnt <= run_cnt + 1'b1;
                if (armed && (run_cnt == CNT_MAX - 1'b1)) overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcrd_classifier.sv
module mcrd_classifier
    import mcrd_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int RATIO_TOL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_vld,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic             overrun,
    output ratio_e           ratio_q,
    output logic             locked_q,
    output logic             osr_q
);
    logic [NUM_RATIOS-1:0] in_win;
    verdict_t              verdict;
    ratio_e                cand;
    logic                  cand_vld;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int NOM = nominal_of(g);
        localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - RATIO_TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + RATIO_TOL);
        assign in_win[g] = (frame_cnt >= LO) && (frame_cnt <= HI);
    end

    always_comb begin
        verdict.hit = |in_win;
        verdict.cls = RATIO_256;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (in_win[i]) verdict.cls = ratio_e'(i[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand     <= RATIO_256;
            cand_vld <= 1'b0;
            ratio_q  <= RATIO_256;
            locked_q <= 1'b0;
            osr_q    <= 1'b0;
        end else if (overrun || (frame_vld && !verdict.hit)) begin
            locked_q <= 1'b0;
            cand_vld <= 1'b0;
        end else if (frame_vld) begin
            if (cand_vld && (cand == verdict.cls)) begin
                ratio_q  <= verdict.cls;
                osr_q    <= (verdict.cls == RATIO_128);
                locked_q <= 1'b1;
            end else begin
                cand     <= verdict.cls;
                cand_vld <= 1'b1;
                if (verdict.cls != ratio_q) locked_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mcrd_stop_watch.sv
module mcrd_stop_watch #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_sync,
    output logic pwrdn_req
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic          tog_prev;
    logic [TW-1:0] idle;
    logic          activity;

    assign activity = tog_sync ^ tog_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_prev  <= 1'b0;
            idle      <= '0;
            pwrdn_req <= 1'b0;
        end else begin
            tog_prev <= tog_sync;
            if (activity) begin
                idle      <= '0;
                pwrdn_req <= 1'b0;
            end else if (idle == TW'(TIMEOUT)) begin
                pwrdn_req <= 1'b1;
            end else begin
                idle <= idle + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mcrd_pkg::*;
#(
    parameter int RATIO_TOL    = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int STOP_TIMEOUT = 4096
) (
    input  logic       mclk,
    input  logic       ref_clk,
    input  logic       rst,
    input  logic       lrclk,
    output logic [1:0] ratio_code,
    output logic       locked,
    output logic       osr_half,
    output logic       pwrdn_req
);
    localparam int CNT_W = $clog2(LARGEST_NOMINAL + RATIO_TOL + 1) + 1;

    logic             lr_sync;
    logic             frame_vld;
    logic [CNT_W-1:0] frame_cnt;
    logic             overrun;
    ratio_e           ratio_q;
    logic             mclk_tog;
    logic             tog_ref;

    mcrd_sync #(.STAGES(SYNC_STAGES)) u_lr_sync (
        .clk (mclk),
        .rst (rst),
        .d   (lrclk),
        .q   (lr_sync)
    );

    mcrd_frame_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (mclk),
        .rst       (rst),
        .lr_sync   (lr_sync),
        .frame_vld (frame_vld),
        .frame_cnt (frame_cnt),
        .overrun   (overrun)
    );

    mcrd_classifier #(.CNT_W(CNT_W), .RATIO_TOL(RATIO_TOL)) u_class (
        .clk       (mclk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .frame_cnt (frame_cnt),
        .overrun   (overrun),
        .ratio_q   (ratio_q),
        .locked_q  (locked),
        .osr_q     (osr_half)
    );

    // Activity marker: flips on every master-clock edge
    always_ff @(posedge mclk) begin
        if (rst) mclk_tog <= 1'b0;
        else     mclk_tog <= ~mclk_tog;
    end

    mcrd_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
        .clk (ref_clk),
        .rst (rst),
        .d   (mclk_tog),
        .q   (tog_ref)
    );

    mcrd_stop_watch #(.TIMEOUT(STOP_TIMEOUT)) u_watch (
        .clk       (ref_clk),
        .rst       (rst),
        .tog_sync  (tog_ref),
        .pwrdn_req (pwrdn_req)
    );

    assign ratio_code = ratio_q;
endmodule

// File: rtl/mcrd_checker.sv
module mcrd_checker
    import mcrd_pkg::*;
#(
    parameter int RATIO_TOL = 2
) (
    input logic                                                   mclk,
    input logic                                                   ref_clk,
    input logic                                                   rst,
    input logic                                                   frame_vld,
    input logic [$clog2(LARGEST_NOMINAL + RATIO_TOL + 1):0]       frame_cnt,
    input logic                                                   overrun,
    input logic [1:0]                                             ratio_code,
    input logic                                                   locked,
    input logic                                                   osr_half,
    input logic                                                   tog_sync,
    input logic                                                   pwrdn_req
);
    localparam int WIDEST = LARGEST_NOMINAL + RATIO_TOL;

    assert_osr_tracks_ratio_R5: assert property (@(posedge mclk) disable iff (rst)
        osr_half == (ratio_code == 2'b00));

    assert_lock_after_frame_R3: assert property (@(posedge mclk) disable iff (rst)
        $rose(locked) |-> $past(frame_vld));

    assert_ratio_moves_on_lock_R3: assert property (@(posedge mclk) disable iff (rst)
        !$stable(ratio_code) |-> $rose(locked));

    assert_wide_count_unlocks_R4: assert property (@(posedge mclk) disable iff (rst)
        (frame_vld && (frame_cnt > WIDEST)) |=> !locked);

    assert_overrun_unlocks_R6: assert property (@(posedge mclk) disable iff (rst)
        overrun |=> !locked);

    assert_wake_needs_edge_R8: assert property (@(posedge ref_clk) disable iff (rst)
        $fell(pwrdn_req) |-> ($past(tog_sync) != $past(tog_sync, 2)));
endmodule

bind mclk_ratio_detect mcrd_checker #(.RATIO_TOL(RATIO_TOL)) u_chk (
    .mclk       (mclk),
    .ref_clk    (ref_clk),
    .rst        (rst),
    .frame_vld  (frame_vld),
    .frame_cnt  (frame_cnt),
    .overrun    (overrun),
    .ratio_code (ratio_code),
    .locked     (locked),
    .osr_half   (osr_half),
    .tog_sync   (tog_ref),
    .pwrdn_req  (pwrdn_req)
);

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;
    localparam int TOL   = 2;
    localparam int TO    = 40;
    localparam int MAXC  = 2047;

    logic       mclk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic       lrclk = 1'b0;
    logic       mclk_run = 1'b1;
    logic [1:0] ratio_code;
    logic       locked;
    logic       osr_half;
    logic       pwrdn_req;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    int  m_ratio  = 1;
    bit  m_locked = 0;
    int  m_cand   = 1;
    bit  m_cand_v = 0;
    bit  have_prev = 0;
    int  prev_p   = 0;

    mclk_ratio_detect #(.RATIO_TOL(TOL), .SYNC_STAGES(2), .STOP_TIMEOUT(TO)) u_dut (
        .mclk       (mclk),
        .ref_clk    (ref_clk),
        .rst        (rst),
        .lrclk      (lrclk),
        .ratio_code (ratio_code),
        .locked     (locked),
        .osr_half   (osr_half),
        .pwrdn_req  (pwrdn_req)
    );

    always #2.5 ref_clk = ~ref_clk;

    always begin
        #4;
        if (mclk_run) mclk = ~mclk;
        else          mclk = 1'b0;
    end

    function automatic int class_of(input int p);
        for (int k = 0; k < 4; k++) begin
            int nom = (k < 3) ? (128 << k) : 768;
            if (p >= nom - TOL && p <= nom + TOL) return k;
        end
        return -1;
    endfunction

    task automatic model_measure(input int p);
        int c = class_of(p);
        if (c < 0) begin
            m_locked = 0;
            m_cand_v = 0;
        end else if (m_cand_v && m_cand == c) begin
            m_ratio  = c;
            m_locked = 1;
        end else begin
            if (c != m_ratio) m_locked = 0;
            m_cand   = c;
            m_cand_v = 1;
        end
    endtask

    task automatic mclk_wait(input int n);
        repeat (n) @(negedge mclk);
    endtask

    task automatic frame(input int p);
        if (have_prev) model_measure(prev_p);
        lrclk = 1'b1;
        have_prev = 1;
        prev_p = p;
        mclk_wait(p / 2);
        lrclk = 1'b0;
        mclk_wait(p - p / 2);
    endtask

    task automatic idle_low(input int n);
        mclk_wait(n);
        if (have_prev && prev_p < MAXC && prev_p + n >= MAXC) begin
            m_locked = 0;
            m_cand_v = 0;
        end
        prev_p += n;
    endtask

    task automatic check_out(input string tag);
        bit exp_osr = (m_ratio == 0);
        n_checks++;
        if (ratio_code !== m_ratio[1:0] || locked !== m_locked || osr_half !== exp_osr) begin
            n_fails++;
            $display("FAIL %s: ratio=%0d locked=%0b osr=%0b expected ratio=%0d locked=%0b osr=%0b",
                     tag, ratio_code, locked, osr_half, m_ratio, m_locked, exp_osr);
        end
    endtask

    task automatic check_pwr(input string tag, input bit exp);
        n_checks++;
        if (pwrdn_req !== exp) begin
            n_fails++;
            $display("FAIL %s: pwrdn_req=%0b expected %0b", tag, pwrdn_req, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge ref_clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (12) @(negedge ref_clk);
        @(negedge mclk);
        check_out("R1");
        check_pwr("R1", 1'b0);
        rst = 1'b0;
        mclk_wait(4);
        check_out("R1");
        check_pwr("R1", 1'b0);

        // R3: first edge arms only; two matching frames to lock
        frame(256);
        frame(256);
        check_out("R3");
        frame(256);
        check_out("R3");

        // R2 / R4: sweep each nominal across the tolerance edges
        for (int k = 0; k < 4; k++) begin
            for (int d = -3; d <= 3; d++) begin
                int nom = (k < 3) ? (128 << k) : 768;
                frame(nom + d);
                frame(nom + d);
                frame(nom + d);
                check_out((d >= -TOL && d <= TOL) ? "R2" : "R4");
            end
        end

        // R9: one differing in-window frame while locked
        frame(512);
        frame(512);
        frame(512);
        check_out("R9");
        frame(256);
        frame(512);
        check_out("R9");

        // R5: lock at 128fs raises the half-rate flag
        frame(128);
        frame(128);
        frame(128);
        frame(128);
        check_out("R5");

        // R6: missing frame edge unlocks, ratio kept
        idle_low(2100);
        check_out("R6");
        frame(256);
        frame(256);
        frame(256);
        frame(256);
        check_out("R2");
        // R6: period of exactly the saturation value, edge and overrun coincide
        frame(MAXC);
        frame(256);
        check_out("R6");
        frame(256);
        frame(256);
        check_out("R3");

        // R7 / R8: master clock stop and resume
        mclk_run = 1'b0;
        repeat (TO - 4) @(negedge ref_clk);
        check_pwr("R7", 1'b0);
        repeat (16) @(negedge ref_clk);
        check_pwr("R7", 1'b1);
        check_out("R8");
        mclk_run = 1'b1;
        idle_low(6);
        check_pwr("R8", 1'b0);
        check_out("R8");
        frame(256);
        frame(256);
        check_out("R4");

        done = 1;
        finish_run();
    end
endmodule